// File: doc/BRIEF.md
# Multiply/Divide Macro-Op Pair Detector

This decode-stage block examines two adjacent 32-bit instruction words and decides whether they form a multiply/divide pair that one execution unit operation can serve. One pair is a high-half product followed by the low-half product of the same operands. The other is a quotient followed by the remainder of the same division. On a match it emits a fused descriptor: the kind of operation, the multiply signedness mode, the two shared source registers, and both destination registers. On a miss the descriptor is all zero, and the two instructions issue on their own.

A match needs more than the right opcodes. The operands must appear in the same order in both words, the signedness of a divide pair must agree, and the first result must not overwrite a source that the second instruction still reads. A parameter adds the 32-bit word-divide forms found on 64-bit cores. The word-multiply form never fuses. The descriptor is registered, so it appears one clock after the pair is presented.

Top module: `mdfuse_pair_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `out_valid` is 0 and every descriptor output is 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. The descriptor for a pair presented in cycle N is visible after the clock edge that ends cycle N.
- R3: A first word with funct3 001, 010 or 011 (high product signed×signed, signed×unsigned, unsigned×unsigned), followed by a second word with funct3 000 (low product), gives `fuse_kind` = 01 and `mul_mode` = the first word's funct3[1:0]. `mul_mode` is 00 for every other kind.
- R4: First funct3 100 with second funct3 110 gives `fuse_kind` = 10 (signed divide). First funct3 101 with second funct3 111 gives 11 (unsigned divide). A pair whose signedness is mixed gives 00.
- R5: Fusion needs the rs1 field [19:15] and the rs2 field [24:20] to be equal across the two words, in the same positions. A swapped operand order gives 00.
- R6: Fusion is refused when the first word's rd field [11:7] equals its rs1 or its rs2. The second word's rd may equal a source.
- R7: Fusion is refused when the two rd fields are equal, or when either rd is 0.
- R8: Both words must carry opcode [6:0] = 0110011 and funct7 [31:25] = 0000001. Any other funct7, a reversed order (low product first), or any other funct3 combination gives 00.
- R9: With `EN_WORD`=1, two divide words with opcode 0111011 fuse under R4–R7, and `word_op` is 1. A pair under opcode 0111011 whose funct3 codes would form a multiply pair never fuses. A pair that mixes the two opcodes never fuses. With `EN_WORD`=0, opcode 0111011 never fuses.
- R10: On a fusion, `src_a`/`src_b` carry the shared rs1/rs2, `dst_first` carries the first word's rd, and `dst_second` carries the second word's rd. When `fuse_kind` is 00, all of these, plus `mul_mode` and `word_op`, are 0.
- R11: When `in_valid` is low, the next cycle shows `fuse_kind` = 00, whatever the instruction inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The two instruction words are meaningful this cycle |
| first_insn | input | 32 | Older instruction word |
| second_insn | input | 32 | Younger instruction word |
| out_valid | output | 1 | Registered copy of in_valid |
| fuse_kind | output | 2 | 00 none, 01 multiply high+low, 10 signed divide, 11 unsigned divide |
| mul_mode | output | 2 | High-product signedness (funct3[1:0] of the first word), 0 otherwise |
| word_op | output | 1 | Fused pair is the 32-bit word divide form |
| src_a | output | 5 | Shared first source register |
| src_b | output | 5 | Shared second source register |
| dst_first | output | 5 | Destination of the high product or the quotient |
| dst_second | output | 5 | Destination of the low product or the remainder |

## Verification
Because the descriptor is a single register stage, a wrong matching rule shows at the ports exactly one clock after the offending pair. It appears either as a nonzero kind for a pair that breaks the operand-order, hazard or destination rules, or as a zero kind for a legal pair. A wrong field routing shows at once as a swapped or stale register number beside a nonzero kind. The scenarios pair every legal form with near-miss variants that differ in one field: swapped sources, an aliased destination, mixed signedness, a wrong funct7 or opcode, and a reversed order. A second instance without the word option confirms that the word forms are rejected there.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
   localparam int ILEN = 32;
   localparam int RAW  = 5;

   localparam logic [6:0] OPC_REG   = 7'b0110011;
   localparam logic [6:0] OPC_REG32 = 7'b0111011;
   localparam logic [6:0] F7_MULDIV = 7'b0000001;

   localparam logic [2:0] F3_MULLO  = 3'b000;
   localparam logic [2:0] F3_MULHSS = 3'b001;
   localparam logic [2:0] F3_MULHSU = 3'b010;
   localparam logic [2:0] F3_MULHUU = 3'b011;
   localparam logic [2:0] F3_QUOS   = 3'b100;
   localparam logic [2:0] F3_QUOU   = 3'b101;
   localparam logic [2:0] F3_REMS   = 3'b110;
   localparam logic [2:0] F3_REMU   = 3'b111;

   typedef enum logic [1:0] {
      FK_NONE = 2'b00,
      FK_MUL  = 2'b01,
      FK_DIVS = 2'b10,
      FK_DIVU = 2'b11
   } fuse_kind_e;

   typedef struct packed {
      logic           md_full;
      logic           md_word;
      logic [2:0]     f3;
      logic [RAW-1:0] rd;
      logic [RAW-1:0] rs1;
      logic [RAW-1:0] rs2;
   } slot_t;

   typedef struct packed {
      fuse_kind_e     kind;
      logic [1:0]     mode;
      logic           word;
      logic [RAW-1:0] sa;
      logic [RAW-1:0] sb;
      logic [RAW-1:0] d1;
      logic [RAW-1:0] d2;
   } desc_t;
endpackage

// File: rtl/mdf_slot_decode.sv
module mdf_slot_decode
   import mdf_pkg::*;
#(
   parameter bit EN_WORD = 1'b1
) (
   input  logic [ILEN-1:0] insn,
   output slot_t           slot
);
   logic [6:0] opc;
   logic [6:0] f7;
   logic       is_md_f7;

   assign opc      = insn[6:0];
   assign f7       = insn[31:25];
   assign is_md_f7 = (f7 == F7_MULDIV);

   always_comb begin
      slot.f3  = insn[14:12];
      slot.rd  = insn[11:7];
      slot.rs1 = insn[19:15];
      slot.rs2 = insn[24:20];
      slot.md_full = is_md_f7 && (opc == OPC_REG);
   end

   generate
      if (EN_WORD) begin : g_word
         assign slot.md_word = is_md_f7 && (opc == OPC_REG32);
      end else begin : g_noword
         assign slot.md_word = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/mdf_pair_rules.sv
module mdf_pair_rules
   import mdf_pkg::*;
(
   input  slot_t a,
   input  slot_t b,
   output desc_t desc
);
   logic full_pair, word_pair;
   logic same_src, hazard_ok, dst_ok;
   logic mul_hit, divs_hit, divu_hit;
   logic gate;

   assign full_pair = a.md_full && b.md_full;
   assign word_pair = a.md_word && b.md_word;
   assign same_src  = (a.rs1 == b.rs1) && (a.rs2 == b.rs2);
   assign hazard_ok = (a.rd != a.rs1) && (a.rd != a.rs2);
   assign dst_ok    = (a.rd != b.rd) && (a.rd != '0) && (b.rd != '0);
   assign gate      = same_src && hazard_ok && dst_ok;

   assign mul_hit  = full_pair && (b.f3 == F3_MULLO) &&
                     ((a.f3 == F3_MULHSS) || (a.f3 == F3_MULHSU) || (a.f3 == F3_MULHUU));
   assign divs_hit = (full_pair || word_pair) && (a.f3 == F3_QUOS) && (b.f3 == F3_REMS);
   assign divu_hit = (full_pair || word_pair) && (a.f3 == F3_QUOU) && (b.f3 == F3_REMU);

   always_comb begin
      desc = '0;
      if (gate && (mul_hit || divs_hit || divu_hit)) begin
         if (mul_hit) begin
            desc.kind = FK_MUL;
            desc.mode = a.f3[1:0];
         end else if (divs_hit) begin
            desc.kind = FK_DIVS;
         end else begin
            desc.kind = FK_DIVU;
         end
         desc.word = word_pair;
         desc.sa   = a.rs1;
         desc.sb   = a.rs2;
         desc.d1   = a.rd;
         desc.d2   = b.rd;
      end
   end
endmodule

// File: rtl/mdfuse_pair_detect.sv
module mdfuse_pair_detect
   import mdf_pkg::*;
#(
   parameter bit EN_WORD = 1'b1,
   parameter int INSN_W  = 32,
   parameter int REG_AW  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] first_insn,
   input  logic [INSN_W-1:0] second_insn,
   output logic              out_valid,
   output logic [1:0]        fuse_kind,
   output logic [1:0]        mul_mode,
   output logic              word_op,
   output logic [REG_AW-1:0] src_a,
   output logic [REG_AW-1:0] src_b,
   output logic [REG_AW-1:0] dst_first,
   output logic [REG_AW-1:0] dst_second
);
   localparam int NSLOT = 2;

   generate
      if (INSN_W != ILEN) begin : g_bad_ilen
         $error("INSN_W must equal the fixed instruction length");
      end
      if (REG_AW != RAW) begin : g_bad_raw
         $error("REG_AW must equal the register index width");
      end
   endgenerate

   logic [INSN_W-1:0] words [NSLOT];
   slot_t             slots [NSLOT];
   desc_t             nxt, cur;
   logic              vld_q;

   assign words[0] = first_insn;
   assign words[1] = second_insn;

   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_slot
         mdf_slot_decode #(.EN_WORD(EN_WORD)) u_dec (
            .insn (words[g]),
            .slot (slots[g])
         );
      end
   endgenerate

   mdf_pair_rules u_rules (
      .a    (slots[0]),
      .b    (slots[1]),
      .desc (nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         cur   <= '0;
      end else begin
         vld_q <= in_valid;
         cur   <= in_valid ? nxt : '0;
      end
   end

   assign out_valid  = vld_q;
   assign fuse_kind  = cur.kind;
   assign mul_mode   = cur.mode;
   assign word_op    = cur.word;
   assign src_a      = cur.sa;
   assign src_b      = cur.sb;
   assign dst_first  = cur.d1;
   assign dst_second = cur.d2;
endmodule

// File: rtl/mdfuse_pair_detect_chk.sv
module mdfuse_pair_detect_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] first_insn,
   input logic [31:0] second_insn,
   input logic        out_valid,
   input logic [1:0]  fuse_kind,
   input logic [1:0]  mul_mode,
   input logic        word_op,
   input logic [4:0]  src_a,
   input logic [4:0]  src_b,
   input logic [4:0]  dst_first,
   input logic [4:0]  dst_second
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                              // R2
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                            // R2
   AST_IDLE_NO_FUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> fuse_kind == 2'b00);                                   // R11
   AST_MODE_MUL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_kind != 2'b01 |-> mul_mode == 2'b00);                            // R3
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_kind == 2'b00 |-> (src_a == 0 && src_b == 0 && dst_first == 0
                              && dst_second == 0 && !word_op));             // R10
   AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_kind != 2'b00 |-> (dst_first != dst_second && dst_first != 0
                              && dst_second != 0));                         // R7
   AST_NO_SRC_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_kind != 2'b00 |-> (dst_first != src_a && dst_first != src_b));   // R6
   AST_WORD_IS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      word_op |-> fuse_kind[1]);                                            // R9
   AST_SRC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid ##1 fuse_kind != 2'b00) |->
         (src_a == $past(second_insn[19:15]) && src_b == $past(second_insn[24:20])));  // R5
endmodule

bind mdfuse_pair_detect mdfuse_pair_detect_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .first_insn(first_insn), .second_insn(second_insn),
   .out_valid(out_valid), .fuse_kind(fuse_kind), .mul_mode(mul_mode),
   .word_op(word_op), .src_a(src_a), .src_b(src_b),
   .dst_first(dst_first), .dst_second(dst_second)
);

// File: tb/tb_mdfuse_pair_detect.sv
module tb_mdfuse_pair_detect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] first_insn = '0;
   logic [31:0] second_insn = '0;
   logic        out_valid, word_op, ov32, wo32;
   logic [1:0]  fuse_kind, mul_mode, fk32, mm32;
   logic [4:0]  src_a, src_b, dst_first, dst_second, sa32, sb32, d132, d232;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mdfuse_pair_detect dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .first_insn(first_insn), .second_insn(second_insn),
      .out_valid(out_valid), .fuse_kind(fuse_kind), .mul_mode(mul_mode),
      .word_op(word_op), .src_a(src_a), .src_b(src_b),
      .dst_first(dst_first), .dst_second(dst_second));

   mdfuse_pair_detect #(.EN_WORD(1'b0)) dut32 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .first_insn(first_insn), .second_insn(second_insn),
      .out_valid(ov32), .fuse_kind(fk32), .mul_mode(mm32),
      .word_op(wo32), .src_a(sa32), .src_b(sb32),
      .dst_first(d132), .dst_second(d232));

   typedef struct {
      logic        v;
      logic [1:0]  k;
      logic [1:0]  m;
      logic        w;
      logic [4:0]  sa, sb, d1, d2;
      logic [1:0]  k32;
      string       tag;
   } exp_t;

   exp_t q[$];

   localparam logic [6:0] OP  = 7'b0110011;
   localparam logic [6:0] OPW = 7'b0111011;
   localparam logic [6:0] MD  = 7'b0000001;

   function automatic logic [31:0] rt(logic [6:0] opc, logic [6:0] f7, logic [2:0] f3,
                                      logic [4:0] rd, logic [4:0] r1, logic [4:0] r2);
      return {f7, r2, r1, f3, rd, opc};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Driver: one pair per cycle, expected descriptor pushed to the scoreboard
   task automatic drive(logic v, logic [31:0] a, logic [31:0] b, logic [1:0] k,
                        logic [1:0] m, logic w, logic [1:0] k32, string tag);
      exp_t e;
      @(negedge clk);
      #1;
      in_valid = v; first_insn = a; second_insn = b;
      e.v = v; e.k = k; e.m = m; e.w = w; e.k32 = k32; e.tag = tag;
      e.sa = (k != 0) ? a[19:15] : 5'd0;
      e.sb = (k != 0) ? a[24:20] : 5'd0;
      e.d1 = (k != 0) ? a[11:7]  : 5'd0;
      e.d2 = (k != 0) ? b[11:7]  : 5'd0;
      q.push_back(e);
   endtask

   // Monitor: one clock after drive (R2), compare at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check({e.tag, " R2 valid"}, 32'(out_valid), 32'(e.v));
         check({e.tag, " kind"}, 32'(fuse_kind), 32'(e.k));
         check({e.tag, " R3 mode"}, 32'(mul_mode), 32'(e.m));
         check({e.tag, " R9 word"}, 32'(word_op), 32'(e.w));
         check({e.tag, " R10 regs"}, {12'd0, src_a, src_b, dst_first, dst_second},
               {12'd0, e.sa, e.sb, e.d1, e.d2});
         check({e.tag, " R9 noword kind"}, 32'(fk32), 32'(e.k32));
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", 32'(out_valid), 0);
      check("R1 reset desc", {22'd0, fuse_kind, mul_mode, word_op, src_a}, 0);
      @(negedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {fuse_kind, dst_first, dst_second, 5'd0, out_valid}, 0);

      drive(1, rt(OP,MD,3'b001,10,1,2), rt(OP,MD,3'b000,11,1,2), 2'b01, 2'b01, 0, 2'b01, "R3 mulh");
      drive(1, rt(OP,MD,3'b010,12,3,4), rt(OP,MD,3'b000,13,3,4), 2'b01, 2'b10, 0, 2'b01, "R3 mulhsu");
      drive(1, rt(OP,MD,3'b011,14,5,6), rt(OP,MD,3'b000,15,5,6), 2'b01, 2'b11, 0, 2'b01, "R3 mulhu");
      drive(1, rt(OP,MD,3'b001,10,1,2), rt(OP,MD,3'b000,1,1,2),  2'b01, 2'b01, 0, 2'b01, "R6 second rd=src ok");
      drive(1, rt(OP,MD,3'b100,5,6,7),  rt(OP,MD,3'b110,8,6,7),  2'b10, 2'b00, 0, 2'b10, "R4 div/rem");
      drive(1, rt(OP,MD,3'b101,20,30,31), rt(OP,MD,3'b111,21,30,31), 2'b11, 2'b00, 0, 2'b11, "R4 divu/remu");
      drive(1, rt(OP,MD,3'b100,5,6,7),  rt(OP,MD,3'b111,8,6,7),  0, 0, 0, 0, "R4 mixed sign");
      drive(1, rt(OP,MD,3'b001,10,1,2), rt(OP,MD,3'b000,11,2,1), 0, 0, 0, 0, "R5 swapped");
      drive(1, rt(OP,MD,3'b100,5,6,7),  rt(OP,MD,3'b110,8,6,9),  0, 0, 0, 0, "R5 rs2 differs");
      drive(1, rt(OP,MD,3'b001,1,1,2),  rt(OP,MD,3'b000,11,1,2), 0, 0, 0, 0, "R6 rd=rs1");
      drive(1, rt(OP,MD,3'b100,7,6,7),  rt(OP,MD,3'b110,8,6,7),  0, 0, 0, 0, "R6 rd=rs2");
      drive(1, rt(OP,MD,3'b001,10,1,2), rt(OP,MD,3'b000,10,1,2), 0, 0, 0, 0, "R7 same rd");
      drive(1, rt(OP,MD,3'b100,0,6,7),  rt(OP,MD,3'b110,8,6,7),  0, 0, 0, 0, "R7 first x0");
      drive(1, rt(OP,MD,3'b100,5,6,7),  rt(OP,MD,3'b110,0,6,7),  0, 0, 0, 0, "R7 second x0");
      drive(1, rt(OP,7'b0,3'b001,10,1,2), rt(OP,MD,3'b000,11,1,2), 0, 0, 0, 0, "R8 funct7");
      drive(1, rt(OP,MD,3'b000,11,1,2), rt(OP,MD,3'b001,10,1,2), 0, 0, 0, 0, "R8 reversed");
      drive(1, rt(OP,MD,3'b001,10,1,2), rt(OP,MD,3'b001,11,1,2), 0, 0, 0, 0, "R8 two highs");
      drive(1, rt(OPW,MD,3'b100,5,6,7), rt(OPW,MD,3'b110,8,6,7), 2'b10, 0, 1, 0, "R9 word div");
      drive(1, rt(OPW,MD,3'b101,5,6,7), rt(OPW,MD,3'b111,8,6,7), 2'b11, 0, 1, 0, "R9 word divu");
      drive(1, rt(OPW,MD,3'b001,10,1,2), rt(OPW,MD,3'b000,11,1,2), 0, 0, 0, 0, "R9 word mul");
      drive(1, rt(OP,MD,3'b100,5,6,7),  rt(OPW,MD,3'b110,8,6,7), 0, 0, 0, 0, "R9 mixed opc");
      drive(0, rt(OP,MD,3'b100,5,6,7),  rt(OP,MD,3'b110,8,6,7),  0, 0, 0, 0, "R11 idle");
      drive(1, rt(OP,MD,3'b100,5,6,7),  rt(OP,MD,3'b110,8,6,7),  2'b10, 0, 0, 2'b10, "R2 back valid");
      drive(0, '0, '0, 0, 0, 0, 0, "R2 drop");
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule